// File: doc/BRIEF.md
# Frequency-Selectable Current Actuator Array

This block drives a bank of digitally controlled load cells that draw periodic current from a shared supply rail. Each run is a security challenge. A key-derived cell mask picks which cells toggle. A key-derived frequency mask picks which excitation frequencies are used. The block then sweeps through the chosen frequencies so that sensors can capture a response across several frequencies. Every frequency is a square wave made by a half-period counter running on the fabric clock. With the default settings and a 200 MHz clock the rates run from 5 MHz down to 1.25 MHz.

A controller loads both masks and pulses `start`. The block latches the masks and begins with the lowest selected frequency. It drives each selected frequency for a fixed number of full periods, then moves to the next higher selected index, and wraps around after the highest. A one-cycle `marker` pulse flags every rising edge of the excitation, so that sensor samples can be phase-aligned. The active index is shown on `freq_idx`. A `stop` pulse ends the run cleanly at the end of the current period. There is no data stream, so every pin is a plain control or status level with no valid/ready handshake.

Top module: `excite_array`

## Requirements
- R1: After reset, `cell_drive` is all zero, `marker` is 0 and `freq_idx` is 0.
- R2: In idle, a `start` pulse with a nonzero `freq_mask` is accepted at that clock edge. In the cycle after that edge, `marker` is 1 and every cell whose latched `cell_mask` bit is 1 drives high. The run opens on the high phase.
- R3: Only cells whose `cell_mask` bit was 1 at the accepted start ever drive high during a run. Disabled cells stay low.
- R4: For frequency index k, the excitation is high for BASE_HP*(k+1) cycles and then low for BASE_HP*(k+1) cycles. With the default BASE_HP=20, index 0 gives 20+20 cycles and index 3 gives 80+80 cycles. Enabled cells follow this wave.
- R5: `marker` is a one-cycle pulse in exactly the first high cycle of every excitation period. It is 0 at all other times.
- R6: A run begins at the lowest set bit of `freq_mask`. After STEP_PERIODS full periods (default 2) it moves to the next higher set bit, and it wraps from the highest set bit back to the lowest. `freq_idx` shows the index in force, as a binary number.
- R7: `freq_idx` changes during a run only in a cycle where `marker` is 1, that is, at a period boundary.
- R8: After a `stop` pulse, the current period finishes its low half. From the point where the next period would have begun, all drives and `marker` stay 0 and the block is idle.
- R9: A `start` pulse during a run is ignored, and so are the `cell_mask` and `freq_mask` values presented with it. A `start` with `freq_mask` all zero is also ignored and leaves all outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run start pulse |
| stop | input | 1 | Run stop pulse; takes effect at the end of the current period |
| cell_mask | input | N_CELLS | Cells to activate, latched at start |
| freq_mask | input | N_FREQ | Frequency indices to sweep, latched at start |
| cell_drive | output | N_CELLS | Toggle enables to the load cells |
| marker | output | 1 | One-cycle pulse at each excitation rising edge |
| freq_idx | output | $clog2(N_FREQ) | Active frequency index |

## Verification
A half-period counter that is off by even one cycle shifts every later marker. It shows up at the second marker of a run, within one period. A wrong sweep pointer gives a wrong `freq_idx` and a wrong marker spacing at the first step boundary, after STEP_PERIODS periods. A lost stop request or a stale mask keeps cells toggling after the expected halt point, or drives cells outside the mask. Either appears within one period of the stimulus.

// File: rtl/excite_pkg.sv
package excite_pkg;
  // half-period length in fabric clocks for a frequency index
  function automatic int unsigned half_period(input int unsigned idx, input int unsigned base);
    return base * (idx + 1);
  endfunction
endpackage

// File: rtl/sweep_seq.sv
module sweep_seq #(
  parameter int N_FREQ       = 4,
  parameter int STEP_PERIODS = 2,
  parameter int IW           = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic [N_FREQ-1:0] freq_mask,
  input  logic              boundary,
  output logic              running,
  output logic [IW-1:0]     idx,
  output logic              launch,
  output logic              halt
);
  localparam int PCW = $clog2(STEP_PERIODS + 1);

  logic [N_FREQ-1:0] fm_q;
  logic              stop_pend;
  logic [PCW-1:0]    pc;
  logic [IW-1:0]     first_idx;
  logic [IW-1:0]     next_idx;

  assign launch = start && !running && (|freq_mask);
  assign halt   = boundary && (stop_pend || stop);

  always_comb begin
    first_idx = '0;
    for (int i = N_FREQ - 1; i >= 0; i--) begin
      if (freq_mask[i]) first_idx = IW'(i);
    end
  end

  always_comb begin
    next_idx = idx;
    for (int k = N_FREQ - 1; k >= 1; k--) begin
      int cand;
      cand = (int'(idx) + k) % N_FREQ;
      if (fm_q[cand]) next_idx = IW'(cand);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      fm_q      <= '0;
      idx       <= '0;
      pc        <= '0;
      stop_pend <= 1'b0;
    end else if (launch) begin
      running   <= 1'b1;
      fm_q      <= freq_mask;
      idx       <= first_idx;
      pc        <= '0;
      stop_pend <= 1'b0;
    end else if (running) begin
      if (stop) stop_pend <= 1'b1;
      if (halt) begin
        running   <= 1'b0;
        stop_pend <= 1'b0;
      end else if (boundary) begin
        if (pc == PCW'(STEP_PERIODS - 1)) begin
          pc  <= '0;
          idx <= next_idx;
        end else begin
          pc <= pc + 1'b1;
        end
      end
    end else begin
      stop_pend <= 1'b0;
    end
  end

  // R6: the active index always belongs to the latched frequency set
  assert_idx_in_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> fm_q[idx]);
endmodule

// File: rtl/halfper_gen.sv
module halfper_gen #(
  parameter int HP_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic            running,
  input  logic            halt,
  input  logic [HP_W-1:0] hp,
  output logic            wave,
  output logic            marker,
  output logic            boundary
);
  logic [HP_W-1:0] cnt;

  assign boundary = running && !wave && (cnt == hp - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      wave   <= 1'b0;
      marker <= 1'b0;
    end else begin
      marker <= 1'b0;
      if (launch) begin
        cnt    <= '0;
        wave   <= 1'b1;
        marker <= 1'b1;
      end else if (running) begin
        if (cnt == hp - 1'b1) begin
          cnt <= '0;
          if (wave) begin
            wave <= 1'b0;
          end else if (!halt) begin
            wave   <= 1'b1;
            marker <= 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt  <= '0;
        wave <= 1'b0;
      end
    end
  end

  // R5: marker only in the first high cycle
  assert_mark_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    marker |-> (wave && !$past(wave)));
  // R4: the counter stays inside the selected half period
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt < hp));
  // R8: the wave is low whenever the sequencer is idle
  assert_wave_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !wave);
endmodule

// File: rtl/cell_gate.sv
module cell_gate #(
  parameter int N_CELLS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic [N_CELLS-1:0] cell_mask,
  input  logic               wave,
  output logic [N_CELLS-1:0] drive
);
  logic [N_CELLS-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      mask_q <= '0;
    else if (launch) mask_q <= cell_mask;
  end

  for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
    assign drive[g] = wave & mask_q[g];
  end
endmodule

// File: rtl/excite_array.sv
module excite_array #(
  parameter int N_CELLS      = 8,
  parameter int N_FREQ       = 4,
  parameter int BASE_HP      = 20,
  parameter int STEP_PERIODS = 2,
  localparam int IW          = $clog2(N_FREQ),
  localparam int HP_W        = $clog2(BASE_HP * N_FREQ + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               stop,
  input  logic [N_CELLS-1:0] cell_mask,
  input  logic [N_FREQ-1:0]  freq_mask,
  output logic [N_CELLS-1:0] cell_drive,
  output logic               marker,
  output logic [IW-1:0]      freq_idx
);
  logic            running, launch, halt, boundary, wave;
  logic [HP_W-1:0] hp;

  sweep_seq #(.N_FREQ(N_FREQ), .STEP_PERIODS(STEP_PERIODS), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .freq_mask(freq_mask), .boundary(boundary), .running(running),
    .idx(freq_idx), .launch(launch), .halt(halt)
  );

  always_comb hp = HP_W'(excite_pkg::half_period(32'(freq_idx), BASE_HP));

  halfper_gen #(.HP_W(HP_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .launch(launch), .running(running),
    .halt(halt), .hp(hp), .wave(wave), .marker(marker), .boundary(boundary)
  );

  cell_gate #(.N_CELLS(N_CELLS)) u_gate (
    .clk(clk), .rst_n(rst_n), .launch(launch), .cell_mask(cell_mask),
    .wave(wave), .drive(cell_drive)
  );

  // R7: frequency index moves only together with a period marker
  assert_freq_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !$stable(freq_idx)) |-> marker);
  // R1: nothing drives and no marker while idle
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (cell_drive == '0 && !marker));
endmodule

// File: tb/test_excite_array.sv
module test_excite_array;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       stop = 1'b0;
  logic [7:0] cell_mask = '0;
  logic [3:0] freq_mask = '0;
  logic [7:0] cell_drive;
  logic       marker;
  logic [1:0] freq_idx;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  excite_array i_excite_array (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .cell_mask(cell_mask), .freq_mask(freq_mask),
    .cell_drive(cell_drive), .marker(marker), .freq_idx(freq_idx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int hpm(input int i);
    return 20 * (i + 1);
  endfunction

  function automatic int first_of(input logic [3:0] fm);
    for (int i = 3; i >= 0; i--) if (fm[i]) first_of = i;
  endfunction

  function automatic int next_of(input logic [3:0] fm, input int cur);
    next_of = cur;
    for (int k = 3; k >= 1; k--) if (fm[(cur + k) % 4]) next_of = (cur + k) % 4;
  endfunction

  // R1 reset state
  task automatic t_reset();
    @(negedge clk);
    chk(cell_drive == 0, "R1 drive", int'(cell_drive), 0);
    chk(marker == 0, "R1 marker", int'(marker), 0);
    chk(freq_idx == 0, "R1 freq_idx", int'(freq_idx), 0);
  endtask

  // run with model of R2..R9; stop pulsed after sample stop_at
  task automatic t_run(input logic [3:0] fm, input logic [7:0] cm,
                       input int len, input int stop_at, input string tag);
    int cur, pc, pstart, pos_next, prev;
    bit stop_req, halted, exp_wave, exp_mk;
    int e_drv, e_mk, e_idx, e_r7, e_r8, e_r9;
    int a_drv, x_drv, a_idx, x_idx;
    logic [7:0] exp_drv;
    e_drv = 0; e_mk = 0; e_idx = 0; e_r7 = 0; e_r8 = 0; e_r9 = 0;
    a_drv = 0; x_drv = 0; a_idx = 0; x_idx = 0;
    cur = first_of(fm); pc = 0; pstart = 0; pos_next = 0; prev = 0;
    stop_req = 0; halted = 0;
    $display("scenario %s", tag);
    start = 1'b1; freq_mask = fm; cell_mask = cm;
    @(negedge clk);
    start = 1'b0;
    chk(marker == 1'b1, "R2 start marker", int'(marker), 1);
    chk(cell_drive == cm, "R2 start drive", int'(cell_drive), int'(cm));
    for (int n = 0; n < len; n++) begin
      exp_mk = 1'b0;
      if (!halted && n == pos_next) begin
        if (stop_req) halted = 1'b1;
        else begin
          if (n > 0) begin
            pc++;
            if (pc == 2) begin pc = 0; cur = next_of(fm, cur); end
          end
          pstart = n; pos_next = n + 2 * hpm(cur); exp_mk = 1'b1;
        end
      end
      exp_wave = !halted && ((n - pstart) < hpm(cur));
      exp_drv = exp_wave ? cm : 8'h00;
      if (cell_drive != exp_drv) begin
        e_drv++; a_drv = int'(cell_drive); x_drv = int'(exp_drv);
        if (n > 30) e_r9++;
      end
      if (marker != exp_mk) e_mk++;
      if (halted && (cell_drive != 0 || marker)) e_r8++;
      if (exp_mk && int'(freq_idx) != cur) begin
        e_idx++; a_idx = int'(freq_idx); x_idx = cur;
      end
      if (n > 0 && !halted && int'(freq_idx) != prev && !marker) e_r7++;
      prev = int'(freq_idx);
      start = (n == 30);
      if (n == 30) begin cell_mask = ~cm; freq_mask = 4'b0001; end
      stop = (n == stop_at);
      if (n == stop_at) stop_req = 1'b1;
      @(negedge clk);
    end
    start = 1'b0; stop = 1'b0;
    chk(e_drv == 0, "R3/R4 drive pattern", a_drv, x_drv);
    chk(e_mk == 0, "R5 marker mismatches", e_mk, 0);
    chk(e_idx == 0, "R6 freq_idx at marker", a_idx, x_idx);
    chk(e_r7 == 0, "R7 off-boundary index change", e_r7, 0);
    chk(halted, "R8 halt reached", int'(halted), 1);
    chk(e_r8 == 0, "R8 activity after halt", e_r8, 0);
    chk(e_r9 == 0, "R9 start during run", e_r9, 0);
  endtask

  // R9 start with empty frequency set
  task automatic t_empty();
    int act;
    act = 0;
    start = 1'b1; freq_mask = 4'b0000; cell_mask = 8'hFF;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 100; n++) begin
      if (cell_drive != 0 || marker) act++;
      @(negedge clk);
    end
    chk(act == 0, "R9 empty freq mask", act, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_run(4'b0100, 8'hA5, 600, 400, "single frequency");
    t_run(4'b1010, 8'h3C, 1600, 1300, "two-frequency sweep");
    t_run(4'b1111, 8'hFF, 1000, 900, "full sweep with wrap");
    t_run(4'b1000, 8'h01, 250, 10, "early stop");
    t_empty();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule